// File: doc/BRIEF.md
# SMM Cache-Coherency Glue Controller

This block is system-side control logic placed next to a processor that supports System Management Mode. It watches the system's SMI request line and the processor's SMM-active acknowledge, and it drives four lines back to the processor: cache flush, cache enable, write-back/write-through select and a gated A20 mask. It also raises a flush request toward an external second-level cache. All of the processor-facing strobes are active-low, except the write-back/write-through select and the second-level flush request. SMM entry is the falling edge of the acknowledge, and SMM exit is its rising edge.

Three static inputs choose the behaviour. One selects write-back or write-through caching. One selects SMRAM overlaid on main memory or SMRAM in a separate region. One chooses whether caching stays on during SMM. In the two write-through modes with overlaid SMRAM, the block flushes on entry, and it flushes again on exit when caching stayed on. In write-back mode with overlaid SMRAM, it flushes together with the SMI request and keeps caching off until SMM ends. In write-back mode with separate SMRAM, it only forces write-through caching for the SMM interval. Flush sequencing works on the acknowledge after a two-flop synchronizer. The A20 mask gating and the SMRAM address steering act combinationally on the raw acknowledge.

The address decoder steers each bus request to main memory, to SMRAM or to refusal. Only the processor reaches SMRAM, and only while the acknowledge is active.

Top module: `smm_glue`

## Requirements
- R1: While reset is held, and right after it, cpu_flush_n is 1, cpu_ken_n is 0, l2_flush_req is 0 and exit_flush_pend is 0. cpu_wbwt equals cfg_wb, where 1 means write-back.
- R2: With cfg_overlay=1 and a request inside the window 38000h–3FFFFh from the processor (bus_master_cpu=1), sel_smram is 1 while smiact_n is 0, and sel_main is 1 while smiact_n is 1. A request outside the window selects main memory. With bus_req=0, none of sel_smram, sel_main and bus_refuse is 1.
- R3: A request from any other master (bus_master_cpu=0) into the overlaid window while smiact_n is 0 selects main memory and never SMRAM.
- R4: With cfg_overlay=0, the overlaid window always selects main memory. The separate SMRAM region A0000h–A7FFFh selects SMRAM only for the processor while smiact_n is 0, and bus_refuse otherwise.
- R5: With cfg_wb=0 and cfg_overlay=1, a falling edge of smiact_n drives cpu_flush_n low and l2_flush_req high from the third rising clock edge after the change, for exactly FLUSH_CLKS (default 2) cycles.
- R6: In that mode with cfg_cache_smm=1, exit_flush_pend rises together with the entry flush. A rising edge of smiact_n then produces a second flush pulse from the third rising edge after the change, and exit_flush_pend clears on that same edge.
- R7: In that mode with cfg_cache_smm=0, cpu_ken_n is 1 from the second rising edge after smiact_n falls until the second rising edge after it rises. No exit flush is issued, and exit_flush_pend stays 0.
- R8: With cfg_wb=1 and cfg_overlay=1, a falling edge of smi_n gives a flush pulse of FLUSH_CLKS cycles starting at the first rising edge after the change. cpu_ken_n is 1 from that edge until the third rising edge after smiact_n rises. Edges of smiact_n cause no flush.
- R9: With cfg_wb=1 and cfg_overlay=0, cpu_wbwt is 0 from the second rising edge after smiact_n falls until the second rising edge after it rises. No flush occurs on any edge.
- R10: cpu_a20m_n is 1 whenever smiact_n is 0, whatever sys_a20m_n is. Otherwise it follows sys_a20m_n in the same cycle.
- R11: With cfg_wb=0 and cfg_overlay=0, no edge of smiact_n or smi_n produces a flush, and cpu_wbwt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wb | input | 1 | 1 = write-back caching system, 0 = write-through |
| cfg_overlay | input | 1 | 1 = SMRAM overlaid on main memory window, 0 = separate region |
| cfg_cache_smm | input | 1 | 1 = caching stays enabled during SMM |
| smi_n | input | 1 | SMI request from system logic, active-low, synchronous |
| smiact_n | input | 1 | SMM-active acknowledge from processor, active-low |
| sys_a20m_n | input | 1 | System A20 mask request, active-low |
| bus_req | input | 1 | A memory access is presented this cycle |
| bus_master_cpu | input | 1 | 1 when the processor owns the current access |
| bus_addr | input | AW | Physical address of the access |
| cpu_flush_n | output | 1 | Cache flush to processor, active-low |
| cpu_ken_n | output | 1 | Cache enable to processor, active-low |
| cpu_wbwt | output | 1 | 1 = write-back permitted, 0 = force write-through |
| cpu_a20m_n | output | 1 | Gated A20 mask to processor, active-low |
| l2_flush_req | output | 1 | Flush request to second-level cache, active-high |
| sel_smram | output | 1 | Access steered to SMRAM |
| sel_main | output | 1 | Access steered to main memory |
| bus_refuse | output | 1 | Access refused |
| exit_flush_pend | output | 1 | A flush is owed at SMM exit |

## Verification
Each result has a fixed due cycle. Flushes tied to the acknowledge appear on the third rising edge after the change: two synchronizer flops and then the edge register that loads the pulse counter. Cache-enable and write-through changes tied to the acknowledge appear on the second edge. A flush started by SMI appears on the first edge. Address steering and A20 gating are due in the same cycle. The bench drives every input on a falling edge and samples on each following falling edge, and it compares every cycle of a window against the expected start cycle and length. A pulse that is early, late, short or long therefore fails on the cycle where it differs.

// File: rtl/smm_glue_pkg.sv
package smm_glue_pkg;

  // Destination chosen for one bus access.
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_MAIN  = 2'd1,
    RT_SMRAM = 2'd2,
    RT_DENY  = 2'd3
  } route_e;

  // Inclusive span test on a zero-extended address.
  function automatic logic in_span(input logic [31:0] addr,
                                   input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/smm_sync.sv
// Multi-flop synchronizer with selectable reset level; also used as reset releaser.
module smm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/smm_flush_seq.sv
// Fixed-length flush pulse generator; a new start reloads the count.
module smm_flush_seq #(
  parameter int FLUSH_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(FLUSH_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) begin
      cnt_d = CW'(FLUSH_CLKS);
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/smm_ctrl.sv
// Mode-dependent SMM entry/exit sequencing of flush, cache enable and WB/WT.
module smm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wb,
  input  logic cfg_overlay,
  input  logic cfg_cache_smm,
  input  logic smi_n,
  input  logic smm_s,
  output logic flush_start,
  output logic ken_n,
  output logic wbwt,
  output logic pend
);

  logic smm_q, smm_d;
  logic smi_q, smi_d;
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic entry, leave, smi_fall;
  logic wt_ov, wb_ov, wb_sep;

  always_comb begin
    wt_ov    = !cfg_wb && cfg_overlay;
    wb_ov    = cfg_wb && cfg_overlay;
    wb_sep   = cfg_wb && !cfg_overlay;
    entry    = smm_s && !smm_q;
    leave    = !smm_s && smm_q;
    smi_fall = smi_q && !smi_n;

    smm_d = smm_s;
    smi_d = smi_n;

    // Exit flush is owed only when write-through caching ran during SMM.
    pend_d = pend_q;
    if (leave && pend_q) begin
      pend_d = 1'b0;
    end else if (entry && wt_ov && cfg_cache_smm) begin
      pend_d = 1'b1;
    end

    // Write-back overlaid: cache held off from SMI until SMM ends.
    hold_d = (wb_ov && smi_fall) || (hold_q && !leave);

    flush_start = (wt_ov && entry) || (wb_ov && smi_fall) || (leave && pend_q);

    ken_n = hold_q || (smm_s && !cfg_cache_smm);
    wbwt  = cfg_wb && !(wb_sep && smm_s);
    pend  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smm_q  <= 1'b0;
      smi_q  <= 1'b1;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      smm_q  <= smm_d;
      smi_q  <= smi_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/smm_route.sv
// Combinational steering of a bus access to main memory, SMRAM or refusal.
module smm_route
  import smm_glue_pkg::*;
#(
  parameter int          AW       = 20,
  parameter logic [31:0] OV_BASE  = 32'h38000,
  parameter logic [31:0] SEP_BASE = 32'hA0000,
  parameter logic [31:0] SPAN     = 32'h08000
) (
  input  logic          smiact_n,
  input  logic          cfg_overlay,
  input  logic          bus_req,
  input  logic          bus_master_cpu,
  input  logic [AW-1:0] bus_addr,
  output route_e        route
);

  localparam logic [31:0] OV_HI  = OV_BASE + SPAN - 32'd1;
  localparam logic [31:0] SEP_HI = SEP_BASE + SPAN - 32'd1;

  logic in_ov, in_sep, smm_grant;

  always_comb begin
    in_ov     = in_span(32'(bus_addr), OV_BASE, OV_HI);
    in_sep    = in_span(32'(bus_addr), SEP_BASE, SEP_HI);
    smm_grant = !smiact_n && bus_master_cpu;

    if (!bus_req) begin
      route = RT_NONE;
    end else if (cfg_overlay) begin
      route = (in_ov && smm_grant) ? RT_SMRAM : RT_MAIN;
    end else if (in_sep) begin
      route = smm_grant ? RT_SMRAM : RT_DENY;
    end else begin
      route = RT_MAIN;
    end
  end

endmodule

// File: rtl/smm_glue.sv
module smm_glue
  import smm_glue_pkg::*;
#(
  parameter int          AW          = 20,
  parameter int          FLUSH_CLKS  = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] OV_BASE     = 32'h38000,
  parameter logic [31:0] SEP_BASE    = 32'hA0000,
  parameter logic [31:0] SPAN        = 32'h08000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wb,
  input  logic          cfg_overlay,
  input  logic          cfg_cache_smm,
  input  logic          smi_n,
  input  logic          smiact_n,
  input  logic          sys_a20m_n,
  input  logic          bus_req,
  input  logic          bus_master_cpu,
  input  logic [AW-1:0] bus_addr,
  output logic          cpu_flush_n,
  output logic          cpu_ken_n,
  output logic          cpu_wbwt,
  output logic          cpu_a20m_n,
  output logic          l2_flush_req,
  output logic          sel_smram,
  output logic          sel_main,
  output logic          bus_refuse,
  output logic          exit_flush_pend
);

  logic   rst_i_n;
  logic   smiact_s_n;
  logic   flush_start;
  logic   flush_busy;
  route_e route;

  // Reset: asserted at once, released after SYNC_STAGES edges.
  smm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_i_n)
  );

  smm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_act_sync (
    .clk    (clk),
    .arst_n (rst_i_n),
    .d      (smiact_n),
    .q      (smiact_s_n)
  );

  smm_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .cfg_wb        (cfg_wb),
    .cfg_overlay   (cfg_overlay),
    .cfg_cache_smm (cfg_cache_smm),
    .smi_n         (smi_n),
    .smm_s         (!smiact_s_n),
    .flush_start   (flush_start),
    .ken_n         (cpu_ken_n),
    .wbwt          (cpu_wbwt),
    .pend          (exit_flush_pend)
  );

  smm_flush_seq #(.FLUSH_CLKS(FLUSH_CLKS)) u_flush (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (flush_start),
    .busy  (flush_busy)
  );

  smm_route #(
    .AW       (AW),
    .OV_BASE  (OV_BASE),
    .SEP_BASE (SEP_BASE),
    .SPAN     (SPAN)
  ) u_route (
    .smiact_n       (smiact_n),
    .cfg_overlay    (cfg_overlay),
    .bus_req        (bus_req),
    .bus_master_cpu (bus_master_cpu),
    .bus_addr       (bus_addr),
    .route          (route)
  );

  always_comb begin
    cpu_flush_n  = !flush_busy;
    l2_flush_req = flush_busy;
    // A20 mask held inactive for the whole SMM interval.
    cpu_a20m_n   = smiact_n ? sys_a20m_n : 1'b1;
    sel_smram    = (route == RT_SMRAM);
    sel_main     = (route == RT_MAIN);
    bus_refuse   = (route == RT_DENY);
  end

endmodule

// File: rtl/smm_glue_chk.sv
module smm_glue_chk #(
  parameter int FLUSH_CLKS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wb,
  input logic cfg_overlay,
  input logic cfg_cache_smm,
  input logic smiact_n,
  input logic sys_a20m_n,
  input logic bus_master_cpu,
  input logic cpu_flush_n,
  input logic cpu_wbwt,
  input logic cpu_a20m_n,
  input logic l2_flush_req,
  input logic sel_smram,
  input logic sel_main,
  input logic bus_refuse,
  input logic exit_flush_pend
);

  a_r10_a20_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !smiact_n |-> cpu_a20m_n);

  a_r10_a20_passes: assert property (@(posedge clk) disable iff (!rst_n)
    smiact_n |-> (cpu_a20m_n == sys_a20m_n));

  a_r2_route_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_smram, sel_main, bus_refuse}));

  a_r3_smram_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
    sel_smram |-> (bus_master_cpu && !smiact_n));

  a_r5_l2_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
    l2_flush_req == !cpu_flush_n);

  a_r5_flush_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    ((FLUSH_CLKS > 1) && $fell(cpu_flush_n)) |=> !cpu_flush_n);

  a_r6_pend_clears_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exit_flush_pend) |-> !cpu_flush_n);

  a_r7_pend_needs_cache: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_flush_pend) |-> (cfg_cache_smm && !cfg_wb && cfg_overlay));

  a_r9_wt_force_only_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wb && !cpu_wbwt) |-> !cfg_overlay);

  a_r11_no_flush_wt_sep: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_flush_n) |-> cfg_overlay);

endmodule

bind smm_glue smm_glue_chk #(.FLUSH_CLKS(FLUSH_CLKS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_wb          (cfg_wb),
  .cfg_overlay     (cfg_overlay),
  .cfg_cache_smm   (cfg_cache_smm),
  .smiact_n        (smiact_n),
  .sys_a20m_n      (sys_a20m_n),
  .bus_master_cpu  (bus_master_cpu),
  .cpu_flush_n     (cpu_flush_n),
  .cpu_wbwt        (cpu_wbwt),
  .cpu_a20m_n      (cpu_a20m_n),
  .l2_flush_req    (l2_flush_req),
  .sel_smram       (sel_smram),
  .sel_main        (sel_main),
  .bus_refuse      (bus_refuse),
  .exit_flush_pend (exit_flush_pend)
);

// File: tb/tb_smm_glue.sv
module tb_smm_glue;

  localparam int AW = 20;
  localparam int FL = 2;

  logic          clk;
  logic          rst_n;
  logic          cfg_wb, cfg_overlay, cfg_cache_smm;
  logic          smi_n, smiact_n, sys_a20m_n;
  logic          bus_req, bus_master_cpu;
  logic [AW-1:0] bus_addr;
  logic          cpu_flush_n, cpu_ken_n, cpu_wbwt, cpu_a20m_n, l2_flush_req;
  logic          sel_smram, sel_main, bus_refuse, exit_flush_pend;

  int checks;
  int fails;

  smm_glue #(.AW(AW), .FLUSH_CLKS(FL)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wb          (cfg_wb),
    .cfg_overlay     (cfg_overlay),
    .cfg_cache_smm   (cfg_cache_smm),
    .smi_n           (smi_n),
    .smiact_n        (smiact_n),
    .sys_a20m_n      (sys_a20m_n),
    .bus_req         (bus_req),
    .bus_master_cpu  (bus_master_cpu),
    .bus_addr        (bus_addr),
    .cpu_flush_n     (cpu_flush_n),
    .cpu_ken_n       (cpu_ken_n),
    .cpu_wbwt        (cpu_wbwt),
    .cpu_a20m_n      (cpu_a20m_n),
    .l2_flush_req    (l2_flush_req),
    .sel_smram       (sel_smram),
    .sel_main        (sel_main),
    .bus_refuse      (bus_refuse),
    .exit_flush_pend (exit_flush_pend)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic in_pulse(input int i, input int start);
    return (i >= start) && (i < start + FL);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flush", 32'(cpu_flush_n), 32'd1);
    chk("R1 ken", 32'(cpu_ken_n), 32'd0);
    chk("R1 l2", 32'(l2_flush_req), 32'd0);
    chk("R1 pend", 32'(exit_flush_pend), 32'd0);
    chk("R1 wbwt", 32'(cpu_wbwt), 32'(cfg_wb));
  endtask

  task automatic route_chk(input string rq, input logic req, input logic cpu,
                           input logic [AW-1:0] a, input logic act_n, input logic [2:0] exp);
    bus_req = req; bus_master_cpu = cpu; bus_addr = a; smiact_n = act_n;
    #1;
    chk(rq, 32'({sel_smram, sel_main, bus_refuse}), 32'(exp));
  endtask

  // Routing checked with combinational settle only; flush side effects settle after.
  task automatic t_route();
    @(negedge clk);
    cfg_overlay = 1'b1; cfg_wb = 1'b0; cfg_cache_smm = 1'b0;
    route_chk("R2 cpu win smm",   1, 1, 20'h38000, 0, 3'b100);
    route_chk("R2 cpu win top",   1, 1, 20'h3FFFF, 0, 3'b100);
    route_chk("R2 cpu win norm",  1, 1, 20'h3A000, 1, 3'b010);
    route_chk("R2 cpu below win", 1, 1, 20'h37FFF, 0, 3'b010);
    route_chk("R2 cpu above win", 1, 1, 20'h40000, 0, 3'b010);
    route_chk("R2 no request",    0, 1, 20'h38000, 0, 3'b000);
    route_chk("R3 other master",  1, 0, 20'h39000, 0, 3'b010);
    cfg_overlay = 1'b0;
    route_chk("R4 ov win sep",    1, 1, 20'h38000, 0, 3'b010);
    route_chk("R4 sep cpu smm",   1, 1, 20'hA0000, 0, 3'b100);
    route_chk("R4 sep cpu norm",  1, 1, 20'hA7FFF, 1, 3'b001);
    route_chk("R4 sep other",     1, 0, 20'hA4000, 0, 3'b001);
    route_chk("R4 sep past end",  1, 1, 20'hA8000, 0, 3'b010);
    bus_req = 1'b0; smiact_n = 1'b1;
    idle(10);
  endtask

  task automatic t_a20();
    @(negedge clk);
    cfg_overlay = 1'b0; cfg_wb = 1'b0;
    sys_a20m_n = 1'b0; smiact_n = 1'b1; #1;
    chk("R10 pass low", 32'(cpu_a20m_n), 32'd0);
    smiact_n = 1'b0; #1;
    chk("R10 blocked", 32'(cpu_a20m_n), 32'd1);
    sys_a20m_n = 1'b1; #1;
    chk("R10 blocked hi", 32'(cpu_a20m_n), 32'd1);
    sys_a20m_n = 1'b0; smiact_n = 1'b1; #1;
    chk("R10 restored", 32'(cpu_a20m_n), 32'd0);
    sys_a20m_n = 1'b1;
    idle(8);
  endtask

  task automatic t_wt_cache();
    @(negedge clk);
    cfg_wb = 1'b0; cfg_overlay = 1'b1; cfg_cache_smm = 1'b1;
    idle(2);
    smiact_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R5 entry flush", 32'(cpu_flush_n), 32'(!in_pulse(i, 3)));
      chk("R5 entry l2", 32'(l2_flush_req), 32'(in_pulse(i, 3)));
      chk("R6 pend set", 32'(exit_flush_pend), 32'(i >= 3));
      chk("R6 ken on", 32'(cpu_ken_n), 32'd0);
    end
    smiact_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R6 exit flush", 32'(cpu_flush_n), 32'(!in_pulse(i, 3)));
      chk("R6 pend clear", 32'(exit_flush_pend), 32'(i < 3));
    end
    idle(4);
  endtask

  task automatic t_wt_nocache();
    @(negedge clk);
    cfg_wb = 1'b0; cfg_overlay = 1'b1; cfg_cache_smm = 1'b0;
    idle(2);
    smiact_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R7 ken off", 32'(cpu_ken_n), 32'(i >= 2));
      chk("R5 flush nc", 32'(cpu_flush_n), 32'(!in_pulse(i, 3)));
      chk("R7 no pend", 32'(exit_flush_pend), 32'd0);
    end
    smiact_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R7 ken back", 32'(cpu_ken_n), 32'(i < 2));
      chk("R7 no exit flush", 32'(cpu_flush_n), 32'd1);
    end
    idle(4);
  endtask

  task automatic t_wb_overlay();
    @(negedge clk);
    cfg_wb = 1'b1; cfg_overlay = 1'b1; cfg_cache_smm = 1'b1;
    idle(2);
    smi_n = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R8 smi flush", 32'(cpu_flush_n), 32'(!in_pulse(i, 1)));
      chk("R8 smi l2", 32'(l2_flush_req), 32'(in_pulse(i, 1)));
      chk("R8 ken off", 32'(cpu_ken_n), 32'd1);
    end
    smiact_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R8 no entry flush", 32'(cpu_flush_n), 32'd1);
      chk("R8 ken held", 32'(cpu_ken_n), 32'd1);
      chk("R8 wbwt kept", 32'(cpu_wbwt), 32'd1);
    end
    smi_n = 1'b1;
    idle(2);
    smiact_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R8 ken release", 32'(cpu_ken_n), 32'(i < 3));
      chk("R8 no exit flush", 32'(cpu_flush_n), 32'd1);
    end
    idle(4);
  endtask

  task automatic t_wb_sep();
    @(negedge clk);
    cfg_wb = 1'b1; cfg_overlay = 1'b0; cfg_cache_smm = 1'b1;
    idle(2);
    smi_n = 1'b0;
    @(negedge clk);
    smiact_n = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R9 wbwt entry", 32'(cpu_wbwt), 32'(i < 2));
      chk("R9 no flush", 32'(cpu_flush_n), 32'd1);
      chk("R9 ken on", 32'(cpu_ken_n), 32'd0);
    end
    smi_n = 1'b1;
    @(negedge clk);
    smiact_n = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R9 wbwt exit", 32'(cpu_wbwt), 32'(i >= 2));
      chk("R9 no exit flush", 32'(cpu_flush_n), 32'd1);
    end
    idle(4);
  endtask

  task automatic t_wt_sep();
    @(negedge clk);
    cfg_wb = 1'b0; cfg_overlay = 1'b0; cfg_cache_smm = 1'b1;
    idle(2);
    smi_n = 1'b0;
    @(negedge clk);
    smiact_n = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R11 no entry flush", 32'(cpu_flush_n), 32'd1);
      chk("R11 wbwt low", 32'(cpu_wbwt), 32'd0);
      chk("R11 no pend", 32'(exit_flush_pend), 32'd0);
    end
    smi_n = 1'b1;
    smiact_n = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R11 no exit flush", 32'(l2_flush_req), 32'd0);
    end
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0;
    cfg_wb = 1'b0; cfg_overlay = 1'b1; cfg_cache_smm = 1'b1;
    smi_n = 1'b1; smiact_n = 1'b1; sys_a20m_n = 1'b1;
    bus_req = 1'b0; bus_master_cpu = 1'b1; bus_addr = '0;
    idle(3);
    t_reset();
    idle(2);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_route();
    t_a20();
    t_wt_cache();
    t_wt_nocache();
    t_wb_overlay();
    t_wb_sep();
    t_wt_sep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule